// File: doc/BRIEF.md
# Bit-Serial Fixed-Coefficient FIR Filter

This block is a direct-form FIR filter that does all of its arithmetic one bit at a time. Samples arrive on a single wire as two's complement words, least significant bit first, and the filtered result leaves on another wire in the same format. A chain of word-length shift registers holds the recent samples. Each tap has a serial-by-parallel multiplier whose signed coefficient is fixed at elaboration. A binary tree of carry-registered serial adders sums the tap products.

The word length is `DATA_W + COEF_W + ceil(log2 TAPS)`. The driver sign-extends each sample to that length, so the full-precision sum cannot overflow. A start pulse on the first bit of every word clears the multipliers, and the adders are cleared by copies of that pulse delayed one stage per level. The delay line never sees this pulse. An asynchronous global reset clears everything, delay line included. One extra word delay after the last tap drives a cascade output, which a second filter can use to extend the tap count.

A two-state sequencer supervises the arithmetic. `FIR_IDLE` is entered on reset, and in it the multipliers are held cleared. The transition *first-start* moves to `FIR_RUN` on the first `word_start`. `FIR_RUN` is left only through the *global-reset* transition back to `FIR_IDLE`.

Top module: `serial_fir`

## Requirements
- R1: Output word k equals the sum over i of `COEFS[i] * x[k-i]`, with `COEFS[0]` applied to the newest sample. Samples taken before the last reset count as zero. Input and output are two's complement, LSB first, `WORD_W = DATA_W + COEF_W + ceil(log2 TAPS)` bits long.
- R2: `word_start` is high during bit 0 of every word, and words follow one another with no gap.
- R3: Output bit b of word k appears on `dout` `ceil(log2 TAPS) + 1` clock edges after the edge that samples input bit b of word k.
- R4: `word_start` clears only the multipliers and adders. The word delays keep their contents, so every output word depends on the previous `TAPS-1` words.
- R5: Asserting `rst_n` low clears the word delays, so samples sent before a reset contribute nothing afterwards.
- R6: `cascade_out` equals `din` delayed by exactly `TAPS * WORD_W` clock edges, which is one word delay after the last tap.
- R7: In `FIR_IDLE` (after reset and before the first `word_start`), `dout` stays 0 whatever `din` carries.
- R8: Full-scale operands are computed exactly, with no overflow: the most negative input, the most positive input, and the most negative and most positive coefficients.
- R9: While `rst_n` is low, `dout` and `cascade_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low global reset, clears the whole filter |
| word_start | input | 1 | High on bit 0 of each word; local clear of multipliers and adders |
| din | input | 1 | Serial sample input, LSB first, sign-extended to `WORD_W` |
| dout | output | 1 | Serial filtered output, LSB first |
| cascade_out | output | 1 | Input stream delayed by `TAPS` words, for chaining filters |

## Verification
A single-sample impulse reads the coefficients out one by one, in tap order. It separates a wrong tap order or a wrong latency from a wrong product. Random sample streams mix all taps, with carries crossing word boundaries, and show that the local clear leaves the history intact while clearing the carries. Streams of full-scale values with alternating signs drive the largest positive and negative sums, where a too-short word or a missing sign extension of the coefficient would show up. A reset in mid-stream followed by an impulse shows that the history was discarded. Random bits fed while the filter is idle show that the output stays quiet.

// File: rtl/serial_fir_pkg.sv
package serial_fir_pkg;

    typedef enum logic {
        FIR_IDLE = 1'b0,
        FIR_RUN  = 1'b1
    } fir_state_t;

    // Number of adder-tree levels needed to reduce TAPS streams to one.
    function automatic int level_count(input int taps);
        return (taps <= 1) ? 0 : $clog2(taps);
    endfunction

    // Streams present at a given tree level.
    function automatic int nodes_at(input int taps, input int lvl);
        return (taps + (1 << lvl) - 1) >> lvl;
    endfunction

endpackage

// File: rtl/serial_fir_wdelay.sv
module serial_fir_wdelay #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [LEN-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[LEN-2:0], d};
        end
    end

    assign q = sr_q[LEN-1];
endmodule

// File: rtl/serial_fir_mult.sv
module serial_fir_mult #(
    parameter int                        COEF_W = 6,
    parameter logic signed [COEF_W-1:0]  COEF   = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hold,
    input  logic y_in,
    output logic p_out
);
    localparam int AW = COEF_W + 2;

    logic signed [AW-1:0] part_q;
    logic signed [AW-1:0] base;
    logic signed [AW-1:0] addend;
    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] coef_ext;

    assign coef_ext = {{2{COEF[COEF_W-1]}}, COEF};

    always_comb begin
        base   = clr ? '0 : part_q;
        addend = y_in ? coef_ext : '0;
        sum    = base + addend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
            p_out  <= 1'b0;
        end else if (hold) begin
            part_q <= '0;
            p_out  <= 1'b0;
        end else begin
            part_q <= sum >>> 1;
            p_out  <= sum[0];
        end
    end

    // R4
    mult_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hold) |=> (p_out == $past(y_in & COEF[0])));
endmodule

// File: rtl/serial_fir_sadd.sv
module serial_fir_sadd (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic a,
    input  logic b,
    output logic s
);
    logic carry_q;
    logic cin;

    assign cin = clr ? 1'b0 : carry_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            s       <= 1'b0;
        end else begin
            carry_q <= (a & b) | (a & cin) | (b & cin);
            s       <= a ^ b ^ cin;
        end
    end

    // R4
    add_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s == $past(a ^ b)));
endmodule

// File: rtl/serial_fir_tree.sv
module serial_fir_tree
    import serial_fir_pkg::*;
#(
    parameter int TAPS = 4,
    localparam int LEVELS = level_count(TAPS),
    localparam int CW     = (LEVELS > 0) ? LEVELS : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   clr_lvl,
    input  logic [TAPS-1:0] prod,
    output logic            sum_out
);
    logic node [0:LEVELS][0:TAPS-1];

    for (genvar j = 0; j < TAPS; j++) begin : g_lvl0
        assign node[0][j] = prod[j];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NIN  = nodes_at(TAPS, l);
        localparam int NOUT = nodes_at(TAPS, l + 1);
        for (genvar j = 0; j < TAPS; j++) begin : g_node
            if (j < NOUT) begin : g_used
                if (2 * j + 1 < NIN) begin : g_add
                    serial_fir_sadd u_add (
                        .clk   (clk),
                        .rst_n (rst_n),
                        .clr   (clr_lvl[l]),
                        .a     (node[l][2*j]),
                        .b     (node[l][2*j+1]),
                        .s     (node[l+1][j])
                    );
                end else begin : g_pass
                    always_ff @(posedge clk or negedge rst_n) begin
                        if (!rst_n) begin
                            node[l+1][j] <= 1'b0;
                        end else begin
                            node[l+1][j] <= node[l][2*j];
                        end
                    end
                end
            end else begin : g_none
                assign node[l+1][j] = 1'b0;
            end
        end
    end

    assign sum_out = node[LEVELS][0];
endmodule

// File: rtl/serial_fir.sv
module serial_fir
    import serial_fir_pkg::*;
#(
    parameter int TAPS   = 4,
    parameter int DATA_W = 8,
    parameter int COEF_W = 6,
    parameter logic [TAPS-1:0][COEF_W-1:0] COEFS = {6'h20, 6'h1F, 6'h3D, 6'h05}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_start,
    input  logic din,
    output logic dout,
    output logic cascade_out
);
    localparam int LEVELS = level_count(TAPS);
    localparam int WORD_W = DATA_W + COEF_W + LEVELS;
    localparam int CW     = (LEVELS > 0) ? LEVELS : 1;

    fir_state_t state_q;
    fir_state_t state_d;
    logic       mult_hold;
    logic [CW-1:0]   clr_q;
    logic [TAPS:0]   tap_in;
    logic [TAPS-1:0] prod;

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FIR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FIR_IDLE: if (word_start) state_d = FIR_RUN;
            FIR_RUN:  state_d = FIR_RUN;
            default:  state_d = FIR_IDLE;
        endcase
    end

    // Sequencer: outputs
    always_comb begin
        mult_hold = 1'b0;
        unique case (state_q)
            FIR_IDLE: mult_hold = !word_start;
            FIR_RUN:  mult_hold = 1'b0;
            default:  mult_hold = 1'b1;
        endcase
    end

    // Clear pulse delayed one stage per tree level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= '0;
        end else begin
            clr_q[0] <= word_start;
            for (int i = 1; i < CW; i++) begin
                clr_q[i] <= clr_q[i-1];
            end
        end
    end

    assign tap_in[0] = din;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        serial_fir_wdelay #(.LEN(WORD_W)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (tap_in[i]),
            .q     (tap_in[i+1])
        );

        serial_fir_mult #(.COEF_W(COEF_W), .COEF(COEFS[i])) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (word_start),
            .hold  (mult_hold),
            .y_in  (tap_in[i]),
            .p_out (prod[i])
        );
    end

    serial_fir_tree #(.TAPS(TAPS)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_lvl (clr_q),
        .prod    (prod),
        .sum_out (dout)
    );

    assign cascade_out = tap_in[TAPS];

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIR_IDLE) |-> !dout);

    // R2
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIR_RUN) |=> (state_q == FIR_RUN));

    // R7
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIR_IDLE && word_start) |=> (state_q == FIR_RUN));

    // R1
    out_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({dout, cascade_out}));
endmodule

// File: tb/tb_serial_fir.sv
module tb_serial_fir;
    localparam int TAPS   = 4;
    localparam int DATA_W = 8;
    localparam int COEF_W = 6;
    localparam int LEVELS = 2;
    localparam int WORD_W = DATA_W + COEF_W + LEVELS;
    localparam int LAT    = LEVELS + 1;
    localparam int LINE   = TAPS * WORD_W;
    localparam int C [TAPS] = '{5, -3, 31, -32};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_start = 1'b0;
    logic din = 1'b0;
    logic dout;
    logic cascade_out;

    int n_cmp = 0;
    int n_bad = 0;
    int tcount = 0;
    bit done = 0;
    longint hist[$];
    logic [WORD_W-1:0] obuf;

    serial_fir #(
        .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
        .COEFS({6'h20, 6'h1F, 6'h3D, 6'h05})
    ) dut (
        .clk(clk), .rst_n(rst_n), .word_start(word_start),
        .din(din), .dout(dout), .cascade_out(cascade_out)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint expect_word(input int k);
        longint acc = 0;
        for (int i = 0; i < TAPS; i++) begin
            if (k - i >= 0) acc += C[i] * hist[k-i];
        end
        return acc;
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One bit time: sample outputs, then drive the next input bit.
    task automatic step_bit(input logic b, input logic st, input string req);
        @(negedge clk);
        // R3: output bit for stream index tcount-LAT is visible now
        if (tcount >= LAT) begin
            int idx = tcount - LAT;
            int bp = idx % WORD_W;
            obuf[bp] = dout;
            if (bp == WORD_W - 1) begin
                int k = idx / WORD_W;
                longint got = longint'($signed(obuf));
                longint exp = expect_word(k);
                check(got == exp, req, $sformatf("word %0d", k), got, exp);
            end
        end
        // R6: cascade is the input delayed by TAPS words
        begin
            logic expb = 1'b0;
            if (tcount >= LINE) begin
                int ci = tcount - LINE;
                longint w = hist[ci / WORD_W];
                logic [WORD_W-1:0] v = w[WORD_W-1:0];
                expb = v[ci % WORD_W];
            end
            if ((tcount % WORD_W) == WORD_W - 1 || cascade_out !== expb)
                check(cascade_out === expb, "R6", "cascade bit",
                      longint'(cascade_out), longint'(expb));
        end
        // R2: start pulse on bit 0, words back to back
        din = b;
        word_start = st;
        tcount++;
    endtask

    task automatic send_word(input longint s, input string req);
        logic [WORD_W-1:0] v;
        hist.push_back(s);
        v = s[WORD_W-1:0];
        for (int b = 0; b < WORD_W; b++) step_bit(v[b], b == 0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b0;
        word_start = 1'b0;
        repeat (3) @(negedge clk);
        check(dout == 1'b0, "R9", "dout in reset", longint'(dout), 0);
        check(cascade_out == 1'b0, "R9", "cascade in reset", longint'(cascade_out), 0);
        rst_n = 1'b1;
        hist.delete();
        tcount = 0;
    endtask

    task automatic test_idle();
        for (int i = 0; i < 2 * WORD_W; i++) begin
            @(negedge clk);
            check(dout == 1'b0, "R7", "dout while idle", longint'(dout), 0);
            din = 1'($urandom);
            word_start = 1'b0;
        end
        do_reset();
    endtask

    task automatic test_impulse(input string req);
        send_word(1, req);
        for (int i = 0; i < TAPS + 1; i++) send_word(0, req);
    endtask

    task automatic test_random();
        for (int i = 0; i < 20; i++) begin
            longint s = longint'($urandom_range(0, 255)) - 128;
            send_word(s, "R4");
        end
    endtask

    task automatic test_extremes();
        for (int i = 0; i < 6; i++) send_word(-128, "R8");
        for (int i = 0; i < 6; i++) send_word(127, "R8");
        for (int i = 0; i < 8; i++) send_word((i % 2) ? 127 : -128, "R8");
        for (int i = 0; i < 8; i++) send_word((i % 2) ? -128 : 127, "R8");
    endtask

    task automatic test_midreset();
        send_word(-100, "R5");
        send_word(90, "R5");
        send_word(-77, "R5");
        send_word(0, "R5");
        do_reset();
        test_impulse("R5");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            report();
        end
    end

    initial begin
        do_reset();
        test_idle();
        test_impulse("R1");
        test_random();
        test_extremes();
        test_midreset();
        send_word(0, "R1");
        send_word(0, "R1");
        done = 1;
        report();
    end
endmodule